// File: doc/BRIEF.md
# MDIO Management Command Controller

This block is a Clause 22 management-bus master that is controlled through one 32-bit command word. Software places an opcode, a 5-bit PHY address, a 5-bit register address and, for a write, 16 bits of data into the word, and sets the start flag in the same write. The block then clocks a complete 64-bit management frame out on MDC/MDIO. When the frame ends it clears the start flag, so that flag doubles as a busy indicator that software polls.

For a read, the master releases MDIO for the turnaround and data phases. It samples the PHY's answer on rising MDC edges and, when the frame completes, places the 16 returned bits in the low half of the same command word. If the PHY fails to pull the second turnaround bit low, a sticky failure flag is raised. That flag stays set until software's next accepted write. MDC is derived from the system clock by an even divide ratio and runs only while a frame is in flight.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset the command word reads 0, MDC is low and MDIO is not driven (mdio_oe = 0).
- R2: A write while idle stores bits 27:0 and bit 29 of the written value. Bit 28 of the written value is ignored and the fail flag reads 0 afterwards. Bits 31:30 always read 0. Bit 29 set launches a frame, and busy (bit 29) reads 1 in the cycle after the write.
- R3: A write while bit 29 reads 1 is ignored. It changes neither the command word nor the frame in progress.
- R4: The frame sent is 32 ones, the start pair 01, opcode bits 27:26, PHY address bits 25:21, register address bits 20:16, the turnaround pair 10 and data bits 15:0, all MSB first. MDIO changes on falling MDC edges and holds steady at rising edges.
- R5: MDC has a period of CLK_DIV system clocks with equal high and low halves. It toggles only while busy and rests low when idle. Busy reads 1 for exactly 64*CLK_DIV cycles, which is far below a 20 ms poll limit.
- R6: For opcode 2'b10 (read) the master drives MDIO for frame bits 0 to 45 and releases it for bits 46 to 63. For any other opcode it drives all 64 bits.
- R7: When a read completes, bits 15:0 hold the 16 bits sampled on the rising MDC edges of frame bits 48 to 63, MSB first. Bits 27:16 are unchanged.
- R8: When a read completes with frame bit 47 sampled as 1, bit 28 is set. It stays set through idle time until the next accepted write clears it. A completed write-type frame leaves bits 15:0 unchanged.
- R9: A write with bit 29 clear only loads the word. No MDC edge occurs and busy stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr_en | input | 1 | Write strobe for the command word |
| cmd_wr_data | input | 32 | Value written to the command word |
| cmd_rd_data | output | 32 | Current command/status word |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable (1 = master drives) |
| mdio_i | input | 1 | Sampled MDIO line |

## Verification
The bench captures every frame bit on rising MDC edges and compares the whole 64-bit pattern and the drive-enable pattern against frames built from the command fields. A design that misplaced a field, released the bus at the wrong bit, or changed MDIO on the rising edge would fail these comparisons. A silent PHY drives the read-fail case, and the bench then checks that the flag persists through idle time but drops on the next write; a non-sticky or never-cleared flag shows up there. A second command issued in the middle of a frame must leave both the word and the frame untouched. A frame launched by a write without the start bit, or an MDC that kept running when idle, is caught by counting MDC edges. The busy window is also counted cycle by cycle against 64 divided-clock periods.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;
  localparam int WORD_W     = 32;
  localparam int DATA_W     = 16;
  localparam int ADDR_W     = 5;
  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;

  localparam int BIT_BUSY   = 29;
  localparam int BIT_FAIL   = 28;
  localparam int OP_HI      = 27;
  localparam int OP_LO      = 26;
  localparam int PHY_LO     = 21;
  localparam int REG_LO     = 16;

  localparam int REL_IDX    = 46;
  localparam int TA2_IDX    = 47;
  localparam int DAT_IDX    = 48;

  typedef enum logic [1:0] {
    OPC_WRITE = 2'b01,
    OPC_READ  = 2'b10
  } mgmt_op_e;

  function automatic logic [FRAME_BITS-1:0] build_frame(
    input logic [1:0]        op,
    input logic [ADDR_W-1:0] phy,
    input logic [ADDR_W-1:0] rga,
    input logic [DATA_W-1:0] dat
  );
    build_frame = {{PRE_BITS{1'b1}}, 2'b01, op, phy, rga, 2'b10, dat};
  endfunction
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int CLK_DIV = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          edge_now;

  assign edge_now = run && (cnt_q == LAST);
  assign rise_stb = edge_now && !mdc_q;
  assign fall_stb = edge_now && mdc_q;
  assign mdc      = mdc_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R5: strobes alternate, a rising strobe only when MDC is low
  assert_rise_from_low_R5: assert property (@(posedge clk) disable iff (rst)
    rise_stb |=> mdc_q);
  assert_fall_from_high_R5: assert property (@(posedge clk) disable iff (rst)
    fall_stb |=> !mdc_q);
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        start_op,
  input  logic [ADDR_W-1:0] start_phy,
  input  logic [ADDR_W-1:0] start_reg,
  input  logic [DATA_W-1:0] start_dat,
  input  logic              rise_stb,
  input  logic              fall_stb,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic              done_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              ta_fail
);
  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] REL_I    = IDX_W'(REL_IDX);
  localparam logic [IDX_W-1:0] TA2_I    = IDX_W'(TA2_IDX);
  localparam logic [IDX_W-1:0] DAT_I    = IDX_W'(DAT_IDX);

  logic                  active_q;
  logic                  rd_q;
  logic [IDX_W-1:0]      idx_q;
  logic [FRAME_BITS-1:0] sh_q;
  logic [DATA_W-1:0]     rx_q;
  logic                  ta_bad_q;
  logic                  o_q, oe_q;
  logic [IDX_W-1:0]      idx_nx;

  assign idx_nx  = idx_q + 1'b1;
  assign done    = active_q && fall_stb && (idx_q == LAST_IDX);
  assign done_rd = done && rd_q;
  assign rx_data = rx_q;
  assign ta_fail = ta_bad_q;
  assign mdio_o  = o_q;
  assign mdio_oe = oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      idx_q    <= '0;
      sh_q     <= '0;
      rx_q     <= '0;
      ta_bad_q <= 1'b0;
      o_q      <= 1'b1;
      oe_q     <= 1'b0;
    end else if (start && !active_q) begin
      active_q <= 1'b1;
      rd_q     <= (start_op == OPC_READ);
      idx_q    <= '0;
      sh_q     <= build_frame(start_op, start_phy, start_reg, start_dat);
      rx_q     <= '0;
      ta_bad_q <= 1'b0;
      o_q      <= 1'b1;
      oe_q     <= 1'b1;
    end else if (active_q) begin
      if (rise_stb) begin
        if (rd_q && idx_q == TA2_I) ta_bad_q <= mdio_i;
        if (idx_q >= DAT_I) rx_q <= {rx_q[DATA_W-2:0], mdio_i};
      end
      if (fall_stb) begin
        if (idx_q == LAST_IDX) begin
          active_q <= 1'b0;
          o_q      <= 1'b1;
          oe_q     <= 1'b0;
        end else begin
          idx_q <= idx_nx;
          sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b0};
          o_q   <= sh_q[FRAME_BITS-2];
          oe_q  <= !(rd_q && idx_nx >= REL_I);
        end
      end
    end
  end

  // R6: a read frame never drives the line from the release bit on
  assert_read_release_R6: assert property (@(posedge clk) disable iff (rst)
    (active_q && rd_q && idx_q >= REL_I) |-> !mdio_oe);
  // R4: MDIO only moves on a falling MDC strobe while a frame runs
  assert_out_stable_R4: assert property (@(posedge clk) disable iff (rst)
    (active_q && !fall_stb && !done) |=> $stable(o_q));
endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
  import mdio_cmd_pkg::*;
#(
  parameter int CLK_DIV = 40
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_wr_en,
  input  logic [31:0] cmd_wr_data,
  output logic [31:0] cmd_rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int FRAME_CYC = FRAME_BITS * CLK_DIV;
  localparam int BC_W      = $clog2(FRAME_CYC) + 1;

  logic [WORD_W-1:0] cmd_q;
  logic              busy;
  logic              wr_take;
  logic              launch;
  logic              rise_stb, fall_stb;
  logic              done, done_rd, ta_fail;
  logic [DATA_W-1:0] rx_data;

  assign busy        = cmd_q[BIT_BUSY];
  assign wr_take     = cmd_wr_en && !busy;
  assign launch      = wr_take && cmd_wr_data[BIT_BUSY];
  assign cmd_rd_data = cmd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
    end else if (wr_take) begin
      cmd_q <= {2'b00, cmd_wr_data[BIT_BUSY], 1'b0, cmd_wr_data[OP_HI:0]};
    end else if (done) begin
      cmd_q[BIT_BUSY] <= 1'b0;
      if (done_rd) begin
        cmd_q[DATA_W-1:0] <= rx_data;
        cmd_q[BIT_FAIL]   <= ta_fail;
      end
    end
  end

  mdio_clk_gen #(.CLK_DIV(CLK_DIV)) clk_gen_i (
    .clk      (clk),
    .rst      (rst),
    .run      (busy),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_frame_seq seq_i (
    .clk       (clk),
    .rst       (rst),
    .start     (launch),
    .start_op  (cmd_wr_data[OP_HI:OP_LO]),
    .start_phy (cmd_wr_data[PHY_LO+ADDR_W-1:PHY_LO]),
    .start_reg (cmd_wr_data[REG_LO+ADDR_W-1:REG_LO]),
    .start_dat (cmd_wr_data[DATA_W-1:0]),
    .rise_stb  (rise_stb),
    .fall_stb  (fall_stb),
    .mdio_i    (mdio_i),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .done      (done),
    .done_rd   (done_rd),
    .rx_data   (rx_data),
    .ta_fail   (ta_fail)
  );

  // busy window counter used only by the checks below
  logic [BC_W-1:0] busy_cnt_q;
  always_ff @(posedge clk) begin
    if (rst || !busy) busy_cnt_q <= '0;
    else              busy_cnt_q <= busy_cnt_q + 1'b1;
  end

  assert_busy_bounded_R5: assert property (@(posedge clk) disable iff (rst)
    busy |-> (busy_cnt_q < BC_W'(FRAME_CYC)));
  assert_idle_mdc_low_R5: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc);
  assert_idle_released_R6: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe);
  assert_busy_write_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && !done && cmd_wr_en) |=> (cmd_q[OP_HI:REG_LO] == $past(cmd_q[OP_HI:REG_LO])));
  assert_fail_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_q[BIT_FAIL] && !wr_take) |=> cmd_q[BIT_FAIL]);
  assert_launch_sets_busy_R2: assert property (@(posedge clk) disable iff (rst)
    launch |=> busy);
endmodule

// File: tb/mdio_cmd_ctrl_tb.sv
module mdio_cmd_ctrl_tb_top;
  localparam int CLK_DIV = 40;
  localparam int HALF    = CLK_DIV / 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_wr_en = 1'b0;
  logic [31:0] cmd_wr_data = '0;
  logic [31:0] cmd_rd_data;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int n_checks = 0;
  int n_fail   = 0;

  // responder state
  int          phy_cnt = 0;
  logic [63:0] cap_line = '0;
  logic [63:0] cap_oe   = '0;
  logic        phy_oe = 1'b0;
  logic        phy_val = 1'b1;
  logic        resp_en = 1'b0;
  logic [15:0] resp_dat = '0;

  always #10 clk = ~clk;

  assign mdio_i = mdio_oe ? mdio_o : (phy_oe ? phy_val : 1'b1);

  mdio_cmd_ctrl #(.CLK_DIV(CLK_DIV)) dut_i (
    .clk(clk), .rst(rst), .cmd_wr_en(cmd_wr_en), .cmd_wr_data(cmd_wr_data),
    .cmd_rd_data(cmd_rd_data), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i));

  always @(posedge mdc) begin
    cap_line <= {cap_line[62:0], mdio_i};
    cap_oe   <= {cap_oe[62:0], mdio_oe};
    phy_cnt  <= phy_cnt + 1;
  end

  // phy_cnt already counts the rise just seen: it is the index of the next bit
  always @(negedge mdc) begin
    if (resp_en && phy_cnt >= 47 && phy_cnt <= 63) begin
      phy_oe  <= 1'b1;
      phy_val <= (phy_cnt == 47) ? 1'b0 : resp_dat[63 - phy_cnt];
    end else begin
      phy_oe  <= 1'b0;
      phy_val <= 1'b1;
    end
  end

  function automatic logic [63:0] frame_of(input logic [31:0] w, input logic rd, input logic [15:0] d);
    if (rd) frame_of = {32'hFFFF_FFFF, 2'b01, w[27:16], 2'b10, d};
    else    frame_of = {32'hFFFF_FFFF, 2'b01, w[27:16], 2'b10, w[15:0]};
  endfunction

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_cmd(input logic [31:0] w);
    @(negedge clk);
    cmd_wr_en   = 1'b1;
    cmd_wr_data = w;
    @(negedge clk);
    cmd_wr_en   = 1'b0;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (cmd_rd_data[29] && cyc < 20000) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic prep_frame();
    phy_cnt = 0;
    cap_line = '0;
    cap_oe = '0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(cmd_rd_data == 32'h0, "R1 word", 64'(cmd_rd_data), 64'h0);
    check(mdc == 1'b0, "R1 mdc", 64'(mdc), 64'h0);
    check(mdio_oe == 1'b0, "R1 oe", 64'(mdio_oe), 64'h0);
  endtask

  task automatic t_write_frame(input logic [31:0] w);
    int cyc;
    prep_frame();
    resp_en = 1'b0;
    write_cmd(w | 32'h2000_0000);
    check(cmd_rd_data[29] == 1'b1, "R2 busy set", 64'(cmd_rd_data[29]), 64'h1);
    wait_idle(cyc);
    check(cyc == 64 * CLK_DIV, "R5 busy length", 64'(cyc), 64'(64 * CLK_DIV));
    check(cap_line == frame_of(w, 1'b0, 16'h0), "R4 write frame", cap_line, frame_of(w, 1'b0, 16'h0));
    check(cap_oe == 64'hFFFF_FFFF_FFFF_FFFF, "R6 write drive", cap_oe, 64'hFFFF_FFFF_FFFF_FFFF);
    check(cmd_rd_data == {4'b0, w[27:0]}, "R8 write done word", 64'(cmd_rd_data), 64'({4'b0, w[27:0]}));
    check(phy_cnt == 64, "R5 mdc edges", 64'(phy_cnt), 64'd64);
  endtask

  task automatic t_mdc_duty();
    int hi, lo, guard;
    int cyc;
    prep_frame();
    write_cmd(32'h2400_0000);
    guard = 0;
    while (!mdc && guard < 1000) begin guard++; @(negedge clk); end
    hi = 0;
    while (mdc && hi < 1000) begin hi++; @(negedge clk); end
    lo = 0;
    while (!mdc && lo < 1000) begin lo++; @(negedge clk); end
    check(hi == HALF, "R5 mdc high", 64'(hi), 64'(HALF));
    check(lo == HALF, "R5 mdc low", 64'(lo), 64'(HALF));
    wait_idle(cyc);
  endtask

  task automatic t_read_ok(input logic [31:0] w, input logic [15:0] d);
    int cyc;
    prep_frame();
    resp_en  = 1'b1;
    resp_dat = d;
    write_cmd(w | 32'h2000_0000);
    wait_idle(cyc);
    resp_en = 1'b0;
    check(cap_line == frame_of(w, 1'b1, d), "R4 read frame", cap_line, frame_of(w, 1'b1, d));
    check(cap_oe == {{46{1'b1}}, 18'h0}, "R6 read release", cap_oe, {{46{1'b1}}, 18'h0});
    check(cmd_rd_data[15:0] == d, "R7 read data", 64'(cmd_rd_data[15:0]), 64'(d));
    check(cmd_rd_data[27:16] == w[27:16], "R7 fields kept", 64'(cmd_rd_data[27:16]), 64'(w[27:16]));
    check(cmd_rd_data[29:28] == 2'b00, "R8 no fail", 64'(cmd_rd_data[29:28]), 64'h0);
  endtask

  task automatic t_read_fail();
    int cyc;
    prep_frame();
    resp_en = 1'b0;
    write_cmd(32'h2BE5_0000);
    wait_idle(cyc);
    check(cmd_rd_data[28] == 1'b1, "R8 fail set", 64'(cmd_rd_data[28]), 64'h1);
    check(cmd_rd_data[15:0] == 16'hFFFF, "R7 idle line data", 64'(cmd_rd_data[15:0]), 64'hFFFF);
    repeat (150) @(negedge clk);
    check(cmd_rd_data[28] == 1'b1, "R8 fail sticky", 64'(cmd_rd_data[28]), 64'h1);
    write_cmd(32'h0442_0000);
    check(cmd_rd_data[28] == 1'b0, "R8 fail cleared", 64'(cmd_rd_data[28]), 64'h0);
  endtask

  task automatic t_busy_ignored();
    int cyc;
    logic [31:0] a, b;
    a = 32'h2561_A5C3;
    b = 32'hEBFF_0F0F;
    prep_frame();
    resp_en = 1'b0;
    write_cmd(a);
    repeat (300) @(negedge clk);
    write_cmd(b);
    check(cmd_rd_data == a, "R3 word during frame", 64'(cmd_rd_data), 64'(a));
    wait_idle(cyc);
    check(cmd_rd_data == {4'b0, a[27:0]}, "R3 word after frame", 64'(cmd_rd_data), 64'({4'b0, a[27:0]}));
    check(cap_line == frame_of(a, 1'b0, 16'h0), "R3 frame untouched", cap_line, frame_of(a, 1'b0, 16'h0));
  endtask

  task automatic t_no_start();
    int edges;
    prep_frame();
    write_cmd(32'hD7AB_1234);
    check(cmd_rd_data == 32'h07AB_1234, "R2 load no start", 64'(cmd_rd_data), 64'h07AB_1234);
    edges = 0;
    repeat (400) begin
      @(negedge clk);
      if (mdc) edges++;
    end
    check(edges == 0 && phy_cnt == 0, "R9 no mdc", 64'(phy_cnt + edges), 64'h0);
    check(cmd_rd_data[29] == 1'b0, "R9 not busy", 64'(cmd_rd_data[29]), 64'h0);
  endtask

  initial begin : watchdog
    int wd;
    wd = 0;
    while (wd < 150000) begin @(posedge clk); wd++; end
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=<150000", wd);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_write_frame(32'h0422_BEEF);
    t_write_frame(32'h07FF_0001);
    t_mdc_duty();
    t_read_ok(32'h0A63_0000, 16'hC3A5);
    t_read_ok(32'h0BFF_0000, 16'h8001);
    t_read_fail();
    t_busy_ignored();
    t_no_start();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule